// File: doc/BRIEF.md
# Coprocessor Control Slave with Sticky Status Flags

This block is the register front end of a modular multiply/exponentiate engine. It is a 32-bit AXI4-Lite slave that decodes a 32 KB window whose base is fixed by a parameter. Inside the window, one read/write control word drives the engine's control outputs. Word writes to a lower region of the window are forwarded to the engine's operand RAM write port.

The control word also carries four status flags. Hardware event inputs set them and software clears them. A level interrupt request stays high while any flag is set. One bit of the word is a self-clearing soft reset. Writing it clears the control word and the flags, and sends a one-cycle reset pulse to the engine. The bus transaction that carries it still completes normally.

The write channel is a state machine with five states. W_IDLE accepts address and data together or either one alone. It moves to W_EXEC when both arrive together, to W_ADDR_HELD when only the address arrives, and to W_DATA_HELD when only the data arrives. W_ADDR_HELD moves to W_EXEC when the data arrives, and W_DATA_HELD moves to W_EXEC when the address arrives. W_EXEC lasts one cycle: the write takes effect there and the response code is fixed. It always moves on to W_RESP. W_RESP presents the response and returns to W_IDLE when the master takes it. The read channel has two states. R_IDLE accepts an address and moves to R_RESP, capturing the read word at that moment. R_RESP holds the data until the master takes it, then returns to R_IDLE.

Top module: `cop_ctrl_slave`

## Requirements
- R1: After reset, every engine control output, the reset pulse and the interrupt are 0, no response is pending, and a read of the control word returns 0.
- R2: The control word sits at window offset 0x6000. Its fields are:
  - bits 31:30: pipeline select (01 lower, 10 upper, 11 full, 00 invalid), stored as written;
  - bits 29:28: destination operand;
  - bits 27:26: x operand;
  - bits 25:24: y operand;
  - bit 23: start;
  - bit 22: mode (0 single multiply, 1 exponentiation).

  Bits 21:16 and 11:0 always read 0.
- R3: Control-word writes honour byte strobes. A lane whose strobe is 0 leaves its bits unchanged. Strobe bit 3 covers bits 31:24, strobe bit 2 covers bits 23:16 and strobe bit 1 covers the flags.
- R4: The flags sit at bit 15 (ready), bit 14 (memory collision), bit 13 (FIFO full) and bit 12 (push error). A 1 on the matching event input sets the flag, and the flag then stays set. A write with 0 in a flag's position clears it. A write with 1 there leaves it unchanged.
- R5: When an event and a software clear of the same flag fall in the same cycle, the flag ends up set.
- R6: The interrupt output is high exactly while at least one flag is set.
- R7: A control-word write with bit 21 set (strobe bit 2 on) clears all fields and flags and raises the engine reset output for exactly one cycle. Bit 21 reads 0 and the write is answered OKAY.
- R8: Write address and write data may arrive together or in either order. Each write performs exactly one update, and no new address or data is accepted while a response is pending.
- R9: A write to offsets 0x0000 to 0x5FFF with all four strobes set produces exactly one RAM write pulse. The RAM word address is offset/4 and the data is the write data. The response is OKAY (code 00).
- R10: A write to the RAM region with any strobe bit 0 produces no RAM write and is answered SLVERR (code 10).
- R11: Addresses outside the window, and in-window offsets above the control word, give an OKAY response and have no effect. Reads of them, and reads of the RAM region, return 0.
- R12: Write and read responses stay valid with stable code and data until the master accepts them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| awaddr | input | 32 | Write address |
| awvalid | input | 1 | Write address valid |
| awready | output | 1 | Write address ready |
| wdata | input | 32 | Write data |
| wstrb | input | 4 | Write byte strobes |
| wvalid | input | 1 | Write data valid |
| wready | output | 1 | Write data ready |
| bresp | output | 2 | Write response code |
| bvalid | output | 1 | Write response valid |
| bready | input | 1 | Write response ready |
| araddr | input | 32 | Read address |
| arvalid | input | 1 | Read address valid |
| arready | output | 1 | Read address ready |
| rdata | output | 32 | Read data |
| rresp | output | 2 | Read response code |
| rvalid | output | 1 | Read data valid |
| rready | input | 1 | Read data ready |
| ev_ready | input | 1 | Engine finished event |
| ev_mem_err | input | 1 | Memory collision event |
| ev_fifo_full | input | 1 | FIFO full event |
| ev_push_err | input | 1 | FIFO push error event |
| pipe_sel | output | 2 | Pipeline part select |
| dest_op | output | 2 | Destination operand index |
| x_op | output | 2 | X operand index |
| y_op | output | 2 | Y operand index |
| start | output | 1 | Start operation |
| exp_mode | output | 1 | Exponentiation mode |
| eng_rst | output | 1 | One-cycle engine reset pulse |
| irq | output | 1 | Interrupt request level |
| ram_we | output | 1 | RAM write strobe |
| ram_waddr | output | 13 | RAM word address |
| ram_wdata | output | 32 | RAM write data |

## Verification
The hardest case to reach is a hardware event that lands in the single cycle in which a software clear of the same flag takes effect. That cycle is W_EXEC, which is never visible at the ports.

The bench reaches it by counting edges from a write that presents address and data together in W_IDLE. Both are accepted on the first edge, so the update happens on the second. The bench raises the event input on the falling edge between those two edges and then reads the flag back.

Data-before-address ordering and byte-strobed partial writes are driven with dedicated sequences, each followed by a read-back.

// File: rtl/cop_pkg.sv
package cop_pkg;

    localparam int          WIN_BITS   = 15;
    localparam logic [14:0] CTRL_OFS   = 15'h6000;
    localparam logic [1:0]  RESP_OKAY  = 2'b00;
    localparam logic [1:0]  RESP_SLV   = 2'b10;
    localparam int          NUM_FLAGS  = 4;
    localparam int          FLAG_LSB   = 12;
    localparam int          SRST_BIT   = 21;

    typedef enum logic [2:0] {
        W_IDLE,
        W_ADDR_HELD,
        W_DATA_HELD,
        W_EXEC,
        W_RESP
    } wr_state_t;

    typedef enum logic {
        R_IDLE,
        R_RESP
    } rd_state_t;

    typedef enum logic [1:0] {
        REG_NONE,
        REG_CTRL,
        REG_RAM
    } region_t;

endpackage

// File: rtl/cop_addr_dec.sv
module cop_addr_dec
    import cop_pkg::*;
#(
    parameter logic [31:0] BASE_ADDR = 32'h4000_0000,
    parameter int          RAM_AW    = WIN_BITS - 2
) (
    input  logic [31:0]       addr,
    output region_t           region,
    output logic [RAM_AW-1:0] ram_word
);

    logic              in_win;
    logic [WIN_BITS-1:0] ofs;

    assign in_win   = (addr[31:WIN_BITS] == BASE_ADDR[31:WIN_BITS]);
    assign ofs      = addr[WIN_BITS-1:0];
    assign ram_word = ofs[WIN_BITS-1:2];

    always_comb begin
        region = REG_NONE;
        if (in_win) begin
            if (ofs[WIN_BITS-1:2] == CTRL_OFS[WIN_BITS-1:2]) begin
                region = REG_CTRL;
            end else if (ofs < CTRL_OFS) begin
                region = REG_RAM;
            end
        end
    end

endmodule

// File: rtl/cop_wr_chan.sv
module cop_wr_chan
    import cop_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [31:0] awaddr,
    input  logic        awvalid,
    output logic        awready,
    input  logic [31:0] wdata,
    input  logic [3:0]  wstrb,
    input  logic        wvalid,
    output logic        wready,
    output logic [1:0]  bresp,
    output logic        bvalid,
    input  logic        bready,
    output logic        cmd_fire,
    output logic [31:0] cmd_addr,
    output logic [31:0] cmd_data,
    output logic [3:0]  cmd_strb,
    input  logic        cmd_err
);

    wr_state_t state_q, state_d;
    logic [1:0] resp_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= W_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            W_IDLE: begin
                if (awvalid && wvalid) begin
                    state_d = W_EXEC;
                end else if (awvalid) begin
                    state_d = W_ADDR_HELD;
                end else if (wvalid) begin
                    state_d = W_DATA_HELD;
                end
            end
            W_ADDR_HELD: if (wvalid)  state_d = W_EXEC;
            W_DATA_HELD: if (awvalid) state_d = W_EXEC;
            W_EXEC:      state_d = W_RESP;
            W_RESP:      if (bready)  state_d = W_IDLE;
            default:     state_d = W_IDLE;
        endcase
    end

    always_comb begin
        awready  = (state_q == W_IDLE) || (state_q == W_DATA_HELD);
        wready   = (state_q == W_IDLE) || (state_q == W_ADDR_HELD);
        cmd_fire = (state_q == W_EXEC);
        bvalid   = (state_q == W_RESP);
        bresp    = resp_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_addr <= '0;
            cmd_data <= '0;
            cmd_strb <= '0;
            resp_q   <= RESP_OKAY;
        end else begin
            if (awvalid && awready) cmd_addr <= awaddr;
            if (wvalid && wready) begin
                cmd_data <= wdata;
                cmd_strb <= wstrb;
            end
            if (state_q == W_EXEC) resp_q <= cmd_err ? RESP_SLV : RESP_OKAY;
        end
    end

    AST_B_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        bvalid && !bready |=> bvalid && $stable(bresp)); // R12
    AST_ONE_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_fire |=> !cmd_fire && bvalid); // R8
    AST_NO_ACCEPT_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        bvalid |-> !awready && !wready); // R8

endmodule

// File: rtl/cop_rd_chan.sv
module cop_rd_chan
    import cop_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        arvalid,
    output logic        arready,
    output logic [31:0] rdata,
    output logic [1:0]  rresp,
    output logic        rvalid,
    input  logic        rready,
    input  logic [31:0] rd_word
);

    rd_state_t state_q, state_d;
    logic [31:0] data_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= R_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            R_IDLE: if (arvalid) state_d = R_RESP;
            R_RESP: if (rready)  state_d = R_IDLE;
            default: state_d = R_IDLE;
        endcase
    end

    always_comb begin
        arready = (state_q == R_IDLE);
        rvalid  = (state_q == R_RESP);
        rdata   = data_q;
        rresp   = RESP_OKAY;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0;
        end else if (arvalid && arready) begin
            data_q <= rd_word;
        end
    end

    AST_R_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid && !rready |=> rvalid && $stable(rdata)); // R12

endmodule

// File: rtl/cop_ctrl_regs.sv
module cop_ctrl_regs
    import cop_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [31:0]          wr_data,
    input  logic [3:0]           wr_strb,
    input  logic [NUM_FLAGS-1:0] events,
    output logic [31:0]          rd_word,
    output logic [7:0]           sel_byte,
    output logic                 start,
    output logic                 exp_mode,
    output logic                 eng_rst,
    output logic                 irq
);

    logic [7:0]           sel_q;
    logic                 start_q;
    logic                 mode_q;
    logic [NUM_FLAGS-1:0] flags_q;
    logic                 srst_cmd;
    logic                 clr_wr;

    assign srst_cmd = wr_en && wr_strb[2] && wr_data[SRST_BIT];
    assign clr_wr   = wr_en && wr_strb[1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q   <= '0;
            start_q <= 1'b0;
            mode_q  <= 1'b0;
            flags_q <= '0;
            eng_rst <= 1'b0;
        end else if (srst_cmd) begin
            sel_q   <= '0;
            start_q <= 1'b0;
            mode_q  <= 1'b0;
            flags_q <= '0;
            eng_rst <= 1'b1;
        end else begin
            eng_rst <= 1'b0;
            if (wr_en && wr_strb[3]) sel_q <= wr_data[31:24];
            if (wr_en && wr_strb[2]) begin
                start_q <= wr_data[23];
                mode_q  <= wr_data[22];
            end
            if (clr_wr) begin
                flags_q <= (flags_q & wr_data[FLAG_LSB+NUM_FLAGS-1:FLAG_LSB]) | events;
            end else begin
                flags_q <= flags_q | events;
            end
        end
    end

    always_comb begin
        rd_word = '0;
        rd_word[31:24] = sel_q;
        rd_word[23]    = start_q;
        rd_word[22]    = mode_q;
        rd_word[FLAG_LSB+NUM_FLAGS-1:FLAG_LSB] = flags_q;
        sel_byte = sel_q;
        start    = start_q;
        exp_mode = mode_q;
        irq      = |flags_q;
    end

    for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag_chk
        AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
            events[i] && !srst_cmd |=> rd_word[FLAG_LSB+i]); // R5
        AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
            rd_word[FLAG_LSB+i] && !clr_wr && !srst_cmd |=> rd_word[FLAG_LSB+i]); // R4
    end

    AST_SRST_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        eng_rst |=> !eng_rst); // R7
    AST_SRST_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        eng_rst |-> !irq && (rd_word == 32'h0)); // R7

endmodule

// File: rtl/cop_ctrl_slave.sv
module cop_ctrl_slave
    import cop_pkg::*;
#(
    parameter logic [31:0] BASE_ADDR = 32'h4000_0000,
    parameter int          RAM_AW    = WIN_BITS - 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [31:0]       awaddr,
    input  logic              awvalid,
    output logic              awready,
    input  logic [31:0]       wdata,
    input  logic [3:0]        wstrb,
    input  logic              wvalid,
    output logic              wready,
    output logic [1:0]        bresp,
    output logic              bvalid,
    input  logic              bready,
    input  logic [31:0]       araddr,
    input  logic              arvalid,
    output logic              arready,
    output logic [31:0]       rdata,
    output logic [1:0]        rresp,
    output logic              rvalid,
    input  logic              rready,
    input  logic              ev_ready,
    input  logic              ev_mem_err,
    input  logic              ev_fifo_full,
    input  logic              ev_push_err,
    output logic [1:0]        pipe_sel,
    output logic [1:0]        dest_op,
    output logic [1:0]        x_op,
    output logic [1:0]        y_op,
    output logic              start,
    output logic              exp_mode,
    output logic              eng_rst,
    output logic              irq,
    output logic              ram_we,
    output logic [RAM_AW-1:0] ram_waddr,
    output logic [31:0]       ram_wdata
);

    logic              cmd_fire;
    logic [31:0]       cmd_addr;
    logic [31:0]       cmd_data;
    logic [3:0]        cmd_strb;
    logic              cmd_err;
    region_t           wr_region;
    region_t           rd_region;
    logic [RAM_AW-1:0] wr_word;
    logic [RAM_AW-1:0] rd_word_unused;
    logic [31:0]       ctrl_word;
    logic [31:0]       rd_word;
    logic [7:0]        sel_byte;
    logic              full_word;

    cop_addr_dec #(.BASE_ADDR(BASE_ADDR), .RAM_AW(RAM_AW)) i_wr_dec (
        .addr(cmd_addr), .region(wr_region), .ram_word(wr_word)
    );

    cop_addr_dec #(.BASE_ADDR(BASE_ADDR), .RAM_AW(RAM_AW)) i_rd_dec (
        .addr(araddr), .region(rd_region), .ram_word(rd_word_unused)
    );

    cop_wr_chan i_wr (
        .clk(clk), .rst_n(rst_n),
        .awaddr(awaddr), .awvalid(awvalid), .awready(awready),
        .wdata(wdata), .wstrb(wstrb), .wvalid(wvalid), .wready(wready),
        .bresp(bresp), .bvalid(bvalid), .bready(bready),
        .cmd_fire(cmd_fire), .cmd_addr(cmd_addr), .cmd_data(cmd_data),
        .cmd_strb(cmd_strb), .cmd_err(cmd_err)
    );

    assign full_word = (cmd_strb == 4'hF);
    assign cmd_err   = (wr_region == REG_RAM) && !full_word;
    assign ram_we    = cmd_fire && (wr_region == REG_RAM) && full_word;
    assign ram_waddr = wr_word;
    assign ram_wdata = cmd_data;

    cop_ctrl_regs i_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_en(cmd_fire && (wr_region == REG_CTRL)),
        .wr_data(cmd_data), .wr_strb(cmd_strb),
        .events({ev_ready, ev_mem_err, ev_fifo_full, ev_push_err}),
        .rd_word(ctrl_word), .sel_byte(sel_byte),
        .start(start), .exp_mode(exp_mode), .eng_rst(eng_rst), .irq(irq)
    );

    assign pipe_sel = sel_byte[7:6];
    assign dest_op  = sel_byte[5:4];
    assign x_op     = sel_byte[3:2];
    assign y_op     = sel_byte[1:0];
    assign rd_word  = (rd_region == REG_CTRL) ? ctrl_word : 32'h0;

    cop_rd_chan i_rd (
        .clk(clk), .rst_n(rst_n),
        .arvalid(arvalid), .arready(arready),
        .rdata(rdata), .rresp(rresp), .rvalid(rvalid), .rready(rready),
        .rd_word(rd_word)
    );

    AST_RAM_OKAY: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |=> bvalid && (bresp == RESP_OKAY)); // R9
    AST_SLVERR_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        bvalid && !$past(bvalid) && (bresp == RESP_SLV) |-> !$past(ram_we)); // R10

endmodule

// File: tb/test_cop_ctrl_slave.sv
module test_cop_ctrl_slave;

    localparam int          CLK_PERIOD = 10;
    localparam logic [31:0] BASE = 32'h4000_0000;
    localparam logic [31:0] CTRL = BASE + 32'h6000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [31:0] awaddr = '0, wdata = '0, araddr = '0;
    logic [3:0]  wstrb = '0;
    logic awvalid = 0, wvalid = 0, bready = 0, arvalid = 0, rready = 0;
    logic ev_ready = 0, ev_mem_err = 0, ev_fifo_full = 0, ev_push_err = 0;
    logic awready, wready, bvalid, arready, rvalid;
    logic [1:0] bresp, rresp, pipe_sel, dest_op, x_op, y_op;
    logic [31:0] rdata, ram_wdata;
    logic start, exp_mode, eng_rst, irq, ram_we;
    logic [12:0] ram_waddr;

    int checks = 0;
    int errors = 0;
    int ram_cnt = 0;
    int rst_cnt = 0;
    logic [12:0] last_waddr;
    logic [31:0] last_wdata;

    always #(CLK_PERIOD/2) clk = ~clk;

    cop_ctrl_slave #(.BASE_ADDR(BASE)) i_cop_ctrl_slave (
        .clk(clk), .rst_n(rst_n),
        .awaddr(awaddr), .awvalid(awvalid), .awready(awready),
        .wdata(wdata), .wstrb(wstrb), .wvalid(wvalid), .wready(wready),
        .bresp(bresp), .bvalid(bvalid), .bready(bready),
        .araddr(araddr), .arvalid(arvalid), .arready(arready),
        .rdata(rdata), .rresp(rresp), .rvalid(rvalid), .rready(rready),
        .ev_ready(ev_ready), .ev_mem_err(ev_mem_err),
        .ev_fifo_full(ev_fifo_full), .ev_push_err(ev_push_err),
        .pipe_sel(pipe_sel), .dest_op(dest_op), .x_op(x_op), .y_op(y_op),
        .start(start), .exp_mode(exp_mode), .eng_rst(eng_rst), .irq(irq),
        .ram_we(ram_we), .ram_waddr(ram_waddr), .ram_wdata(ram_wdata)
    );

    always @(negedge clk) begin
        if (ram_we) begin
            ram_cnt++;
            last_waddr = ram_waddr;
            last_wdata = ram_wdata;
        end
        if (eng_rst) rst_cnt++;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // order: 0 together, 1 address first, 2 data first
    task automatic axi_write(input logic [31:0] a, input logic [31:0] d,
                             input logic [3:0] s, input int order,
                             output logic [1:0] resp);
        bit a_pend, w_pend, a_take, w_take;
        @(negedge clk);
        awaddr = a; wdata = d; wstrb = s;
        a_pend = (order != 2);
        w_pend = (order != 1);
        awvalid = a_pend; wvalid = w_pend;
        if (order == 1) w_pend = 1;
        if (order == 2) a_pend = 1;
        while (a_pend || w_pend) begin
            a_take = awvalid && awready;
            w_take = wvalid && wready;
            @(negedge clk);
            if (a_take) begin
                a_pend = 0; awvalid = 0;
                if (w_pend) wvalid = 1;
            end
            if (w_take) begin
                w_pend = 0; wvalid = 0;
                if (a_pend) awvalid = 1;
            end
        end
        while (!bvalid) @(negedge clk);
        resp = bresp;
        bready = 1;
        @(negedge clk);
        bready = 0;
    endtask

    task automatic axi_read(input logic [31:0] a, output logic [31:0] d);
        @(negedge clk);
        araddr = a; arvalid = 1;
        while (!arready) @(negedge clk);
        @(negedge clk);
        arvalid = 0;
        while (!rvalid) @(negedge clk);
        d = rdata;
        bready = 0;
        rready = 1;
        @(negedge clk);
        rready = 0;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        check("R1 irq", {31'b0, irq}, 32'h0);
        check("R1 outputs", {20'b0, pipe_sel, dest_op, x_op, y_op, start, exp_mode, eng_rst, ram_we},
              32'h0);
        check("R1 bvalid", {31'b0, bvalid}, 32'h0);
        axi_read(CTRL, d);
        check("R1 ctrl read", d, 32'h0);
    endtask

    task automatic t_fields();
        logic [1:0] r;
        logic [31:0] d;
        axi_write(CTRL, 32'hD5DF_0FFF, 4'hF, 0, r);
        check("R2 resp", {30'b0, r}, 32'h0);
        axi_read(CTRL, d);
        check("R2 readback", d, 32'hD5C0_0000);
        check("R2 outputs", {26'b0, pipe_sel, dest_op, x_op, y_op, start, exp_mode} >> 0,
              {26'b0, 2'b11, 2'b01, 2'b01, 2'b01, 1'b1, 1'b1});
        axi_write(CTRL, 32'h8000_0000, 4'b1000, 0, r);
        axi_read(CTRL, d);
        check("R3 byte lane", d, 32'h80C0_0000);
    endtask

    task automatic t_order();
        logic [1:0] r;
        int base_cnt;
        base_cnt = ram_cnt;
        axi_write(BASE + 32'h10, 32'hCAFE_0001, 4'hF, 2, r);
        check("R8 data first count", ram_cnt - base_cnt, 1);
        check("R9 waddr", {19'b0, last_waddr}, 32'd4);
        check("R9 wdata", last_wdata, 32'hCAFE_0001);
        check("R9 resp", {30'b0, r}, 32'h0);
        axi_write(BASE + 32'h5FFC, 32'h1234_5678, 4'hF, 1, r);
        check("R8 addr first count", ram_cnt - base_cnt, 2);
        check("R9 top word", {19'b0, last_waddr}, 32'h17FF);
    endtask

    task automatic t_partial();
        logic [1:0] r;
        int base_cnt;
        base_cnt = ram_cnt;
        axi_write(BASE + 32'h20, 32'hFFFF_FFFF, 4'b0011, 0, r);
        check("R10 resp", {30'b0, r}, 32'h2);
        check("R10 no write", ram_cnt - base_cnt, 0);
    endtask

    task automatic t_flags();
        logic [1:0] r;
        logic [31:0] d;
        @(negedge clk);
        ev_ready = 1; ev_mem_err = 1; ev_push_err = 1; ev_fifo_full = 1;
        @(negedge clk);
        ev_ready = 0; ev_mem_err = 0; ev_push_err = 0; ev_fifo_full = 0;
        check("R6 irq set", {31'b0, irq}, 32'h1);
        axi_read(CTRL, d);
        check("R4 flags set", d & 32'h0000_F000, 32'h0000_F000);
        axi_write(CTRL, 32'h40C0_B000, 4'hF, 0, r);
        axi_read(CTRL, d);
        check("R4 clear one", d, 32'h40C0_B000);
        check("R6 irq held", {31'b0, irq}, 32'h1);
        axi_write(CTRL, 32'h40C0_0000, 4'hF, 0, r);
        axi_read(CTRL, d);
        check("R4 clear all", d, 32'h40C0_0000);
        check("R6 irq low", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_set_wins();
        logic [31:0] d;
        @(negedge clk);
        awaddr = CTRL; wdata = 32'h40C0_0000; wstrb = 4'hF;
        awvalid = 1; wvalid = 1;
        @(negedge clk);
        awvalid = 0; wvalid = 0;
        ev_mem_err = 1;
        @(negedge clk);
        ev_mem_err = 0;
        while (!bvalid) @(negedge clk);
        bready = 1;
        @(negedge clk);
        bready = 0;
        axi_read(CTRL, d);
        check("R5 set wins", d & 32'h0000_F000, 32'h0000_4000);
    endtask

    task automatic t_srst();
        logic [1:0] r;
        logic [31:0] d;
        int base_cnt;
        base_cnt = rst_cnt;
        axi_write(CTRL, 32'h0020_4000, 4'hF, 0, r);
        check("R7 resp", {30'b0, r}, 32'h0);
        check("R7 pulse count", rst_cnt - base_cnt, 1);
        axi_read(CTRL, d);
        check("R7 cleared", d, 32'h0);
        check("R7 irq", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_outside();
        logic [1:0] r;
        logic [31:0] d;
        int base_cnt;
        axi_write(CTRL, 32'hC000_0000, 4'hF, 0, r);
        base_cnt = ram_cnt;
        axi_write(BASE + 32'h8010, 32'hFFFF_FFFF, 4'hF, 0, r);
        check("R11 outside resp", {30'b0, r}, 32'h0);
        axi_write(BASE + 32'h7000, 32'hFFFF_FFFF, 4'hF, 0, r);
        check("R11 unused resp", {30'b0, r}, 32'h0);
        check("R11 no ram", ram_cnt - base_cnt, 0);
        axi_read(CTRL, d);
        check("R11 ctrl untouched", d, 32'hC000_0000);
        axi_read(BASE + 32'h16010, d);
        check("R11 outside read", d, 32'h0);
        axi_read(BASE + 32'h10, d);
        check("R11 ram read", d, 32'h0);
    endtask

    task automatic t_hold();
        logic [31:0] d;
        @(negedge clk);
        araddr = CTRL; arvalid = 1;
        @(negedge clk);
        arvalid = 0;
        repeat (3) @(negedge clk);
        check("R12 rvalid held", {31'b0, rvalid}, 32'h1);
        d = rdata;
        check("R12 rdata", d, 32'hC000_0000);
        rready = 1;
        @(negedge clk);
        rready = 0;
        check("R12 released", {31'b0, rvalid}, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_fields();
        t_order();
        t_partial();
        t_flags();
        t_set_wins();
        t_srst();
        t_outside();
        t_hold();
        repeat (2) @(negedge clk);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        checks++;
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule